// File: doc/BRIEF.md
# Serial-port to I2S format converter

This block sits between a synchronous serial port and an external I2S audio link. In conversion mode it takes the port's serial bit clock, drives an I2S-framed stream (a word-select line and MSB-first data, two 16-bit words per frame, left word first) and turns the received I2S stream back into words for the port side. Words move on the port side through valid/ready handshakes. When conversion is off, every serial signal passes straight through.

A 6-bit control register sets the behaviour:

| Bit | Function |
|-----|----------|
| 0 | I2S select |
| 1 | converter enable |
| 2 | word-select polarity |
| 3 | word-select timing |
| 4 | clock inversion |
| 5 | internal loopback |

Conversion is active only when bits 0 and 1 are both 1. The block always acts as the master: the word-select line is generated from the incoming bit clock. The path runs on a copy of the control register that lags the readable value by one system clock.

Transmit back-pressure rule: `tx_ready` pulses for one system clock at each word boundary. A word is taken only when `tx_valid` is high in that cycle. If `tx_valid` is low, a zero word is sent and the link keeps its timing.

Receive rule: `rx_valid` stays high until `rx_ready` accepts the word. The link cannot be stalled, so a new word that completes while the previous one is still waiting replaces it.

Top module: `ssp_i2s_conv`

## Requirements
- R1: The control register sits at byte offset 0. Its bits 5:0 are read/write and bits 31:6 read as 0. Any other offset reads 0 and ignores writes. Reset value is 0.
- R2: A control write shows on `reg_rdata` in the cycle after the write edge. The data path only follows it one system clock later.
- R3: While bit 0 or bit 1 is 0, the following hold:
  - `i2s_sck` = `ssp_sck`, `i2s_ws` = `ssp_fs`, `i2s_sd_out` = `ssp_txd`, and `ssp_rxd` = `i2s_sd_in`, combinationally.
  - `rx_valid` stays 0.
- R4: Leaving the active state clears the path registers. After re-entry, the first falling edge of `ssp_sck` starts a left word. A rising edge before that edge is ignored.
- R5: Data changes after each falling edge of `ssp_sck`, MSB first, in this order:
  - a left word, then a right word;
  - each word is loaded at its first bit (`tx_ready` pulse);
  - each word is zero when `tx_valid` is low.
- R6: With bit 3 = 0 (I2S timing), word-select changes one bit before each word's MSB. With bit 3 = 1 (left-justified), it changes on the MSB.
- R7: With bit 2 = 0, word-select is 0 during the left word. With bit 2 = 1, it is 1 during the left word.
- R8: While active, `i2s_sck` equals `ssp_sck` XOR bit 4.
- R9: Receive data is sampled on the rising edge of `ssp_sck`, MSB first. Each completed word sets `rx_valid`, with `rx_right` = 1 for a right word. An unaccepted word is held, and a newer word replaces it.
- R10: With bit 5 = 1, the transmit data is received internally and `i2s_sd_in` is ignored. The first four words (two frames) after loopback becomes active are received as 0.
- R11: `tx_ready` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 8 | register byte offset |
| reg_wdata | input | 6 | register write data (control bits only) |
| reg_rdata | output | 32 | register read data |
| ssp_sck | input | 1 | serial port bit clock |
| ssp_fs | input | 1 | serial port frame sync |
| ssp_txd | input | 1 | serial port transmit data |
| ssp_rxd | output | 1 | serial port receive data |
| tx_data | input | 16 | transmit word |
| tx_valid | input | 1 | transmit word valid |
| tx_ready | output | 1 | transmit word taken |
| rx_data | output | 16 | received word |
| rx_right | output | 1 | received word is the right channel |
| rx_valid | output | 1 | received word valid |
| rx_ready | input | 1 | received word accepted |
| i2s_sck | output | 1 | I2S bit clock |
| i2s_ws | output | 1 | I2S word select |
| i2s_sd_out | output | 1 | I2S serial data out |
| i2s_sd_in | input | 1 | I2S serial data in |

## Verification
The embedded properties check the following on every cycle:
- the bit position only ever steps by one;
- `tx_ready` never lasts more than a cycle;
- a waiting received word is held under back-pressure;
- the loopback fill words are zero;
- no receive word appears while the converter is inactive.

The bench scenarios cover what the properties cannot, comparing against words computed in the bench:
- exact word-select placement for both timings and both polarities;
- bit order and zero words on underrun;
- the clock inversion;
- the one-clock control lag;
- exact pass-through with random pin values;
- the overwrite of an unaccepted word.

// File: rtl/ssp_i2s_pkg.sv
package ssp_i2s_pkg;
  parameter int unsigned CTRL_W = 6;

  typedef struct packed {
    logic loop;     // bit 5
    logic clk_inv;  // bit 4
    logic lj_mode;  // bit 3
    logic ws_inv;   // bit 2
    logic enable;   // bit 1
    logic i2s_sel;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/ssp_i2s_ctrl_regs.sv
module ssp_i2s_ctrl_regs
  import ssp_i2s_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_act_o
);
  localparam int unsigned PAD_W = DATA_W - CTRL_W;

  ctrl_t ctrl_q;
  logic  hit;

  assign hit = (addr_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      ctrl_act_o <= '0;
    end else begin
      if (we_i && hit) ctrl_q <= ctrl_t'(wdata_i);
      ctrl_act_o <= ctrl_q;
    end
  end

  assign rdata_o = hit ? {{PAD_W{1'b0}}, ctrl_q} : '0;
endmodule

// File: rtl/ssp_i2s_tx.sv
module ssp_i2s_tx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr_i,
  input  logic                              fall_i,
  input  logic                              lj_i,
  input  logic                              wsinv_i,
  input  logic [WORD_W-1:0]                 tx_data_i,
  input  logic                              tx_valid_i,
  output logic                              load_o,
  output logic                              sd_o,
  output logic                              ws_o,
  output logic [$clog2(2*WORD_W)-1:0]       pos_o,
  output logic                              started_o
);
  localparam int unsigned POS_W = $clog2(2*WORD_W);
  localparam int unsigned LOW_W = POS_W - 1;

  logic [POS_W-1:0]  pos_q, nxt, nxt2;
  logic [WORD_W-1:0] sh_q;
  logic              ws_q, started_q;

  assign nxt    = pos_q + POS_W'(1);
  assign nxt2   = pos_q + POS_W'(2);
  assign load_o = fall_i && (nxt[LOW_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '1;
      sh_q      <= '0;
      ws_q      <= 1'b0;
      started_q <= 1'b0;
    end else if (clr_i) begin
      pos_q     <= '1;
      sh_q      <= '0;
      ws_q      <= 1'b0;
      started_q <= 1'b0;
    end else if (fall_i) begin
      pos_q     <= nxt;
      started_q <= 1'b1;
      if (load_o) sh_q <= tx_valid_i ? tx_data_i : '0;
      else        sh_q <= {sh_q[WORD_W-2:0], 1'b0};
      ws_q      <= (lj_i ? nxt[POS_W-1] : nxt2[POS_W-1]) ^ wsinv_i;
    end
  end

  assign sd_o      = sh_q[WORD_W-1];
  assign ws_o      = ws_q;
  assign pos_o     = pos_q;
  assign started_o = started_q;

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    ($past(started_q) && !$stable(pos_q)) |-> (pos_q == POS_W'($past(pos_q) + 1'b1))); // R5
endmodule

// File: rtl/ssp_i2s_rx.sv
module ssp_i2s_rx #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ZERO_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        rise_i,
  input  logic [$clog2(2*WORD_W)-1:0] pos_i,
  input  logic                        din_i,
  input  logic                        loop_i,
  input  logic                        rdy_i,
  output logic [WORD_W-1:0]           data_o,
  output logic                        right_o,
  output logic                        valid_o
);
  localparam int unsigned POS_W = $clog2(2*WORD_W);
  localparam int unsigned LOW_W = POS_W - 1;
  localparam int unsigned ZC_W  = $clog2(ZERO_WORDS + 1);

  logic [WORD_W-2:0] sh_q;
  logic [ZC_W-1:0]   zcnt_q;
  logic              word_done, fill_zero;

  assign word_done = rise_i && (pos_i[LOW_W-1:0] == '1);
  assign fill_zero = loop_i && (zcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      zcnt_q  <= ZC_W'(ZERO_WORDS);
      data_o  <= '0;
      right_o <= 1'b0;
      valid_o <= 1'b0;
    end else if (clr_i) begin
      sh_q    <= '0;
      zcnt_q  <= ZC_W'(ZERO_WORDS);
      data_o  <= '0;
      right_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      if (rise_i) sh_q <= {sh_q[WORD_W-3:0], din_i};
      if (!loop_i)                zcnt_q <= ZC_W'(ZERO_WORDS);
      else if (word_done && fill_zero) zcnt_q <= zcnt_q - 1'b1;
      if (word_done) begin
        valid_o <= 1'b1;
        right_o <= pos_i[POS_W-1];
        data_o  <= fill_zero ? '0 : {sh_q, din_i};
      end else if (valid_o && rdy_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  AST_LOOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (word_done && fill_zero) |=> (data_o == '0)); // R10
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (valid_o && !rdy_i) |=> valid_o); // R9
endmodule

// File: rtl/ssp_i2s_conv.sv
module ssp_i2s_conv
  import ssp_i2s_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ssp_sck,
  input  logic              ssp_fs,
  input  logic              ssp_txd,
  output logic              ssp_rxd,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_right,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              i2s_sck,
  output logic              i2s_ws,
  output logic              i2s_sd_out,
  input  logic              i2s_sd_in
);
  localparam int unsigned POS_W = $clog2(2*WORD_W);

  ctrl_t            act;
  logic             active, clr, sck_d, fall, rise, started;
  logic             sd, ws, rx_din;
  logic [POS_W-1:0] pos;

  ssp_i2s_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .ctrl_act_o(act)
  );

  assign active = act.i2s_sel && act.enable;
  assign clr    = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= ssp_sck;
  end

  assign fall   = active && sck_d && !ssp_sck;
  assign rise   = active && started && !sck_d && ssp_sck;
  assign rx_din = act.loop ? sd : i2s_sd_in;

  ssp_i2s_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .fall_i(fall),
    .lj_i(act.lj_mode), .wsinv_i(act.ws_inv),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .load_o(tx_ready),
    .sd_o(sd), .ws_o(ws), .pos_o(pos), .started_o(started)
  );

  ssp_i2s_rx #(.WORD_W(WORD_W), .ZERO_WORDS(4)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .rise_i(rise), .pos_i(pos),
    .din_i(rx_din), .loop_i(act.loop), .rdy_i(rx_ready),
    .data_o(rx_data), .right_o(rx_right), .valid_o(rx_valid)
  );

  assign i2s_sck    = active ? (ssp_sck ^ act.clk_inv) : ssp_sck;
  assign i2s_ws     = active ? ws : ssp_fs;
  assign i2s_sd_out = active ? sd : ssp_txd;
  assign ssp_rxd    = active ? 1'b0 : i2s_sd_in;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready); // R11
  AST_IDLE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> !rx_valid); // R3
endmodule

// File: tb/ssp_i2s_conv_test.sv
module ssp_i2s_conv_test;
  localparam int WORD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [5:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ssp_sck = 1'b0, ssp_fs = 1'b0, ssp_txd = 1'b0, ssp_rxd;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [15:0] rx_data;
  logic        rx_right, rx_valid;
  logic        rx_ready = 1'b1;
  logic        i2s_sck, i2s_ws, i2s_sd_out;
  logic        i2s_sd_in = 1'b0;

  int nchk = 0, nfail = 0, rxj = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [5:0]  cur = '0;
  logic [15:0] words [0:63];
  logic [15:0] rxw   [0:63];
  bit          txv   [0:63];

  always #10 clk = ~clk;

  ssp_i2s_conv uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ssp_sck(ssp_sck),
    .ssp_fs(ssp_fs), .ssp_txd(ssp_txd), .ssp_rxd(ssp_rxd),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_right(rx_right), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .i2s_sck(i2s_sck), .i2s_ws(i2s_ws),
    .i2s_sd_out(i2s_sd_out), .i2s_sd_in(i2s_sd_in)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] texp(input int w);
    return txv[w] ? words[w] : 16'h0;
  endfunction

  function automatic logic ws_exp(input int k, input logic [5:0] c);
    int slot = c[3] ? (k / WORD) : ((k + 1) / WORD);
    return logic'(slot % 2) ^ c[2];
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [5:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(reg_rdata, exp, tag);
    reg_addr = 8'h0;
  endtask

  // received-word monitor (R9, R10)
  always @(negedge clk) begin
    if (mon_on && rx_valid && rx_ready) begin
      if (cur[5]) chk(32'(rx_data), 32'((rxj < 4) ? 16'h0 : texp(rxj)), "R10 loop word");
      else        chk(32'(rx_data), 32'(rxw[rxj]), "R9 rx word");
      chk(32'(rx_right), 32'(rxj % 2), "R9 rx channel");
      rxj++;
    end
  end

  task automatic run_i2s(input logic [5:0] c, input int nbits, input bit hold);
    int nw = nbits / WORD;
    for (int i = 0; i < nw; i++) begin
      words[i] = 16'($urandom);
      rxw[i]   = 16'($urandom);
      txv[i]   = ($urandom % 5) != 0;
    end
    ssp_sck = 1'b0;
    wr(8'h0, 6'h00);
    idle(3);
    cur = c; rxj = 0; rx_ready = !hold; mon_on = 1'b1;
    wr(8'h0, c);
    idle(3);
    @(negedge clk) ssp_sck = 1'b1;      // R4: rise before first fall is ignored
    idle(4);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      tx_data = words[k / WORD]; tx_valid = txv[k / WORD];
      i2s_sd_in = rxw[k / WORD][WORD - 1 - (k % WORD)];
      ssp_sck = 1'b0;
      idle(4);
      chk(32'(i2s_sd_out), 32'(texp(k / WORD)[WORD - 1 - (k % WORD)]), "R5 data bit");
      chk(32'(i2s_ws), 32'(ws_exp(k, c)), c[3] ? "R6 ws left-justified" : "R6/R7 ws i2s timing");
      chk(32'(i2s_sck), 32'(c[4]), "R8 clock polarity");
      ssp_sck = 1'b1;
      idle(3);
    end
    idle(6);
    if (hold) begin
      chk(32'(rxj), 32'd0, "R9 no transfer while not ready");
      chk(32'(rx_valid), 32'd1, "R9 held word");
      rxj = nw - 1;                       // newest word replaced older ones
      @(posedge clk); #2 rx_ready = 1'b1;
      idle(3);
    end
    chk(32'(rxj), 32'(nw), "R9 word count");
    mon_on = 1'b0;
    rx_ready = 1'b1;
  endtask

  task automatic pass_chk(input logic [5:0] c);
    wr(8'h0, c);
    idle(2);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      ssp_sck = 1'($urandom); ssp_fs = 1'($urandom);
      ssp_txd = 1'($urandom); i2s_sd_in = 1'($urandom);
      #1;
      chk({28'h0, i2s_sck, i2s_ws, i2s_sd_out, ssp_rxd},
          {28'h0, ssp_sck, ssp_fs, ssp_txd, i2s_sd_in}, "R3 pass-through");
      chk(32'(rx_valid), 32'd0, "R3 rx idle");
    end
    ssp_sck = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    rd_chk(8'h0, 32'h0, "R1 reset value");
    // R1 register map
    wr(8'h4, 6'h3F);
    rd_chk(8'h0, 32'h0, "R1 other offset write ignored");
    rd_chk(8'h4, 32'h0, "R1 other offset reads zero");
    wr(8'h0, 6'h3F);
    rd_chk(8'h0, 32'h3F, "R1 rw bits");
    wr(8'h0, 6'h2A);
    rd_chk(8'h0, 32'h2A, "R1 rw pattern");
    // R3 pass-through variants
    pass_chk(6'h00);
    pass_chk(6'h3D);
    pass_chk(6'h3E);
    // R2 one-clock lag
    wr(8'h0, 6'h00);
    idle(2);
    ssp_fs = 1'b1; ssp_sck = 1'b0;
    wr(8'h0, 6'h03);
    #1 chk(reg_rdata, 32'h03, "R2 read shows new value");
    chk(32'(i2s_ws), 32'd1, "R2 path still lags");
    @(negedge clk);
    #1 chk(32'(i2s_ws), 32'd0, "R2 path follows one clock later");
    ssp_fs = 1'b0;
    // I2S scenarios
    run_i2s(6'h03, 96, 1'b0);   // R6 i2s timing, R7 polarity 0
    run_i2s(6'h07, 96, 1'b0);   // R7 inverted
    run_i2s(6'h0B, 96, 1'b0);   // R6 left-justified
    run_i2s(6'h0F, 96, 1'b0);
    run_i2s(6'h13, 64, 1'b0);   // R8
    run_i2s(6'h23, 128, 1'b0);  // R10
    run_i2s(6'h2F, 128, 1'b0);  // R10 with LJ and inversion
    run_i2s(6'h03, 64, 1'b1);   // R9 back-pressure, R4 restart
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule